// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Controller

This block lets four processor cores (harts) interrupt one another through a small register space. The space has pending, priority, enable and claim/complete registers. A sender raises an interrupt by writing a 1 into its own slice of a shared pending word. The pending word is write-1-to-set. A write can set bits but never clears them. Inside each slice, the targets are laid out in reverse order. Each target hart enables the matching bit from every sender's slice, using one mask per hart.

A target hart takes work by reading its claim/complete register. The block returns the best eligible source, clears that source's pending bit and marks the source as owned by that hart. The hart later writes the same ID back to release the source. One claim read followed by one completion write also clears a stale interrupt during warm start. Each hart has a level interrupt output that shows whether it has any source it could claim.

The register port is a plain single-cycle access port with no back-pressure. The block accepts a write in the cycle `bus_en` and `bus_we` are both high. A read answers one cycle later on `bus_rvalid`/`bus_rdata`. The requester must take that answer in that cycle, because it is not held.

Top module: `swi_ctrl`

## Requirements
- R1: A write to byte offset 0x1000 sets every pending bit whose `bus_wdata` bit is 1 and leaves all other pending bits unchanged. A write never clears a pending bit. A read of 0x1000 returns the pending word.
- R2: Sender s interrupts target t by setting pending bit 8*s + 7 - t, so bit 7 of each sender slice targets hart 0 and bit 4 targets hart 3. The source ID of pending bit b is b + 1, and ID 0 means "none".
- R3: The priority of source ID n (1..32) is at byte offset 4*n, is 3 bits wide and reads back zero-extended. Offset 0, offsets above 4*32 and unaligned offsets are unmapped: writes have no effect and reads return 0.
- R4: The 32-bit enable mask of hart h is at byte offset 0x2000 + 0x80*h and reads back as written. Bit b enables source ID b + 1 for hart h.
- R5: A read of hart h's claim register at byte offset 0x200004 + 0x1000*h returns the ID of the eligible source with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible. A source is eligible for hart h when it is pending, enabled for h, unowned and has nonzero priority.
- R6: A claim read that returns a nonzero ID clears that source's pending bit and makes h its owner in the same access.
- R7: An owned source is not eligible for any hart, even if it is pended again, until its owner completes it.
- R8: Writing ID n to hart h's claim register releases source n if h owns it. Any other completion write, including one from a different hart, has no effect.
- R9: `irq[h]` is high exactly when hart h has at least one eligible source. It follows state changes in the cycle after the access that caused them.
- R10: A source with priority 0 never raises an interrupt and is never returned by a claim.
- R11: Every read gives `bus_rvalid` high for exactly one cycle, the cycle after the read. A write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all state |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read) |
| bus_rdata | output | 32 | Read data |
| irq | output | 4 | Per-hart interrupt request level |

## Verification
The assertions check the following on every cycle:
- the read response timing;
- that pending bits fall only through a claim, and that a successful claim removes exactly one pending bit;
- that no interrupt is raised while nothing is pending.

The bench's scenarios cover the rest:
- the reverse sender/target bit layout;
- priority arbitration with ties going to the lowest ID;
- masking of owned sources while they are pended again;
- completion writes that are ignored when the ID is wrong or comes from another hart;
- the priority-zero exclusion.

A behavioural model compares every interrupt line and every read response against these rules on each clock.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_PEND,
    ACC_EN,
    ACC_CLAIM
  } acc_kind_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int HARTS  = 4,
  parameter int NSRC   = 32,
  parameter int HW     = 2,
  parameter int IDW    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [HW-1:0]     hart,
  output logic [IDW-1:0]    id
);
  logic [ADDR_W-13:0] page;
  logic [9:0]         word;

  assign page = addr[ADDR_W-1:12];
  assign word = addr[11:2];

  always_comb begin
    kind = ACC_NONE;
    hart = '0;
    id   = '0;
    if (addr[1:0] == 2'b00) begin
      if (page == '0) begin
        if (word >= 10'd1 && word <= 10'(NSRC)) begin
          kind = ACC_PRIO;
          id   = addr[IDW+1:2];
        end
      end else if (page == (ADDR_W-12)'(1)) begin
        if (word == '0) kind = ACC_PEND;
      end else if (page == (ADDR_W-12)'(2)) begin
        if (addr[6:2] == '0 && addr[11:7] < 5'(HARTS)) begin
          kind = ACC_EN;
          hart = addr[7+HW-1:7];
        end
      end else if (addr[ADDR_W-1] && addr[ADDR_W-2:12] < (ADDR_W-13)'(HARTS)
                   && word == 10'd1) begin
        kind = ACC_CLAIM;
        hart = addr[12+HW-1:12];
      end
    end
  end
endmodule

// File: rtl/swi_pick.sv
module swi_pick #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int IDW    = 6
) (
  input  logic [NSRC-1:0]   elig,
  input  logic [PRIO_W-1:0] prio [NSRC],
  output logic [IDW-1:0]    id,
  output logic              any
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare: equal priority keeps the lower ID.
  always_comb begin
    best = '0;
    id   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (id == '0 || prio[i] > best)) begin
        best = prio[i];
        id   = IDW'(i + 1);
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl
  import swi_pkg::*;
#(
  parameter int HARTS  = 4,
  parameter int REGION = 8,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic [HARTS-1:0]  irq
);
  localparam int NSRC = HARTS * REGION;  // at most 32: one pending word
  localparam int IDW  = $clog2(NSRC + 1);
  localparam int SW   = $clog2(NSRC);
  localparam int HW   = (HARTS > 1) ? $clog2(HARTS) : 1;

  logic [NSRC-1:0]   pend_q;
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   en_q   [HARTS];
  logic [NSRC-1:0]   own_q  [HARTS];

  acc_kind_e      kind;
  logic [HW-1:0]  dec_hart;
  logic [IDW-1:0] dec_id;

  swi_decode #(
    .ADDR_W(ADDR_W), .HARTS(HARTS), .NSRC(NSRC), .HW(HW), .IDW(IDW)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .hart(dec_hart), .id(dec_id)
  );

  logic [NSRC-1:0] owned_any;
  logic [NSRC-1:0] prio_nz;

  always_comb begin
    owned_any = '0;
    for (int h = 0; h < HARTS; h++) owned_any = owned_any | own_q[h];
    for (int i = 0; i < NSRC; i++) prio_nz[i] = |prio_q[i];
  end

  logic [IDW-1:0] pick_id  [HARTS];
  logic [HARTS-1:0] pick_any;

  for (genvar h = 0; h < HARTS; h++) begin : g_hart
    logic [NSRC-1:0] elig;
    assign elig = pend_q & en_q[h] & ~owned_any & prio_nz;
    swi_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick (
      .elig(elig), .prio(prio_q), .id(pick_id[h]), .any(pick_any[h])
    );
  end

  assign irq = pick_any;

  logic           rd, wr, claim_take;
  logic [IDW-1:0] claim_id;
  logic [SW-1:0]  claim_idx, prio_idx, done_idx;
  logic [IDW-1:0] done_id;
  logic           done_ok;

  assign rd         = bus_en && !bus_we;
  assign wr         = bus_en && bus_we;
  assign claim_id   = pick_id[dec_hart];
  assign claim_take = rd && kind == ACC_CLAIM && pick_any[dec_hart];
  assign claim_idx  = SW'(claim_id - 1'b1);
  assign prio_idx   = SW'(dec_id - 1'b1);
  assign done_id    = bus_wdata[IDW-1:0];
  assign done_idx   = SW'(done_id - 1'b1);
  assign done_ok    = wr && kind == ACC_CLAIM && bus_wdata[31:IDW] == '0
                      && done_id >= IDW'(1) && done_id <= IDW'(NSRC)
                      && own_q[dec_hart][done_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int h = 0; h < HARTS; h++) begin
        en_q[h]  <= '0;
        own_q[h] <= '0;
      end
    end else begin
      if (wr && kind == ACC_PEND) pend_q <= pend_q | bus_wdata[NSRC-1:0];
      if (wr && kind == ACC_PRIO) prio_q[prio_idx] <= bus_wdata[PRIO_W-1:0];
      if (wr && kind == ACC_EN) en_q[dec_hart] <= bus_wdata[NSRC-1:0];
      if (claim_take) begin
        pend_q[claim_idx]          <= 1'b0;
        own_q[dec_hart][claim_idx] <= 1'b1;
      end
      if (done_ok) own_q[dec_hart][done_idx] <= 1'b0;
    end
  end

  logic [31:0] rd_mux;

  always_comb begin
    unique case (kind)
      ACC_PRIO:  rd_mux = 32'(prio_q[prio_idx]);
      ACC_PEND:  rd_mux = 32'(pend_q);
      ACC_EN:    rd_mux = 32'(en_q[dec_hart]);
      ACC_CLAIM: rd_mux = 32'(claim_id);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/swi_ctrl_checker.sv
module swi_ctrl_checker #(
  parameter int HARTS = 4,
  parameter int NSRC  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic             bus_rvalid,
  input logic [HARTS-1:0] irq,
  input logic [NSRC-1:0]  pend_q,
  input logic             claim_take
);
  a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);

  a_r11_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid);

  a_r1_write_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_take |=> (($past(pend_q) & ~pend_q) == '0));

  a_r6_claim_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    claim_take |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (irq == '0));
endmodule

bind swi_ctrl swi_ctrl_checker #(.HARTS(HARTS), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_rvalid(bus_rvalid), .irq(irq), .pend_q(pend_q), .claim_take(claim_take)
);

// File: tb/swi_ctrl_test.sv
module swi_ctrl_test;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  swi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  // Behavioural model
  bit m_pend [32];
  int m_prio [33];
  bit [31:0] m_en [4];
  int m_own [32];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_pick(int h);
    int best = 0;
    int bp = 0;
    for (int id = 1; id <= 32; id++) begin
      if (m_pend[id-1] && m_en[h][id-1] && m_own[id-1] < 0 && m_prio[id] != 0
          && (best == 0 || m_prio[id] > bp)) begin
        best = id;
        bp = m_prio[id];
      end
    end
    return best;
  endfunction

  function automatic bit [31:0] m_pend_word();
    bit [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[i] = m_pend[i];
    return w;
  endfunction

  function automatic int ipi_bit(int s, int t);
    return 8*s + 7 - t;
  endfunction

  // One access: returns read data; model is advanced in step with the edge.
  task automatic acc(bit we, int a, bit [31:0] d, string req, output logic [31:0] got);
    bit [31:0] exp = '0;
    int ch = -1;
    int eh = -1;
    int pid = 0;
    bit pe = 0;
    if (a % 4 == 0) begin
      if (a < 'h1000 && a/4 >= 1 && a/4 <= 32) pid = a/4;
      else if (a == 'h1000) pe = 1;
      else if (a >= 'h2000 && a < 'h2200 && (a - 'h2000) % 'h80 == 0) eh = (a - 'h2000) / 'h80;
      else if (a >= 'h200004 && (a - 'h200004) % 'h1000 == 0 && (a - 'h200004) / 'h1000 < 4)
        ch = (a - 'h200004) / 'h1000;
    end
    if (!we) begin
      if (pid != 0) exp = m_prio[pid];
      else if (pe) exp = m_pend_word();
      else if (eh >= 0) exp = m_en[eh];
      else if (ch >= 0) exp = m_pick(ch);
    end
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = 22'(a); bus_wdata = d;
    @(posedge clk);
    if (we) begin
      if (pid != 0) m_prio[pid] = d & 7;
      if (pe) for (int i = 0; i < 32; i++) if (d[i]) m_pend[i] = 1;
      if (eh >= 0) m_en[eh] = d;
      if (ch >= 0 && d >= 1 && d <= 32 && m_own[d-1] == ch) m_own[d-1] = -1;
    end else if (ch >= 0 && exp != 0) begin
      m_pend[exp-1] = 0;
      m_own[exp-1] = ch;
    end
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    got = bus_rdata;
    if (we) chk(bus_rvalid == 1'b0, "R11", 32'(bus_rvalid), 0);
    else begin
      chk(bus_rvalid == 1'b1, "R11", 32'(bus_rvalid), 1);
      chk(bus_rdata == exp, req, bus_rdata, exp);
    end
  endtask

  task automatic wr(int a, bit [31:0] d, string req);
    logic [31:0] g;
    acc(1, a, d, req, g);
  endtask

  task automatic rd(int a, string req, output logic [31:0] g);
    acc(0, a, 0, req, g);
  endtask

  function automatic int claim_addr(int h);
    return 'h200004 + 'h1000*h;
  endfunction

  // Every-clock comparison of the interrupt lines against the model (R9)
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int h = 0; h < 4; h++)
        chk(irq[h] == (m_pick(h) != 0), "R9", 32'(irq[h]), 32'(m_pick(h) != 0));
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    for (int i = 0; i < 32; i++) begin m_pend[i] = 0; m_own[i] = -1; end
    for (int i = 0; i <= 32; i++) m_prio[i] = 0;
    for (int h = 0; h < 4; h++) m_en[h] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 4'h0, "R9", 32'(irq), 0);
    chk(bus_rvalid == 1'b0, "R11", 32'(bus_rvalid), 0);
    cmp_on = 1;
    rd('h1000, "R1", g);
    chk(g == 0, "R1", g, 0);

    // Cold init: priorities 1, per-hart shifted enable masks
    for (int id = 1; id <= 32; id++) wr(4*id, 1, "R3");
    for (int h = 0; h < 4; h++) wr('h2000 + 'h80*h, 32'h80808080 >> h, "R4");
    rd('h2000 + 'h80*2, "R4", g);
    chk(g == 32'h20202020, "R4", g, 32'h20202020);
    rd(4*17, "R3", g);
    chk(g == 1, "R3", g, 1);
    wr(0, 7, "R3");
    rd(0, "R3", g);
    chk(g == 0, "R3", g, 0);
    wr(4*33, 7, "R3");
    rd(4*33, "R3", g);
    chk(g == 0, "R3", g, 0);

    // Source with no enable anywhere: bit 0 (id 1)
    wr('h1000, 32'h1, "R4");
    chk(irq == 4'h0, "R4", 32'(irq), 0);

    // Hart 0 interrupts hart 2: bit 5, id 6
    wr('h1000, 32'(1) << ipi_bit(0, 2), "R2");
    chk(irq == 4'b0100, "R2", 32'(irq), 32'b0100);
    wr('h1000, 32'h0, "R1");
    rd('h1000, "R1", g);
    chk(g == 32'h21, "R1", g, 32'h21);

    rd(claim_addr(2), "R5", g);
    chk(g == 6, "R5", g, 6);
    rd('h1000, "R6", g);
    chk(g == 32'h1, "R6", g, 32'h1);

    // Pended again while owned: stays hidden
    wr('h1000, 32'(1) << ipi_bit(0, 2), "R7");
    chk(irq[2] == 1'b0, "R7", 32'(irq[2]), 0);
    rd(claim_addr(2), "R7", g);
    chk(g == 0, "R7", g, 0);
    wr(claim_addr(2), 7, "R8");
    wr(claim_addr(1), 6, "R8");
    chk(irq[2] == 1'b0, "R8", 32'(irq[2]), 0);
    wr(claim_addr(2), 6, "R8");
    chk(irq[2] == 1'b1, "R8", 32'(irq[2]), 1);
    rd(claim_addr(2), "R5", g);
    chk(g == 6, "R5", g, 6);
    wr(claim_addr(2), 6, "R8");

    // Arbitration at hart 1 from senders 0,1,3: ids 7,15,31
    wr(4*15, 5, "R5");
    wr(4*31, 5, "R5");
    wr('h1000, (32'(1) << ipi_bit(0,1)) | (32'(1) << ipi_bit(1,1)) | (32'(1) << ipi_bit(3,1)), "R2");
    rd(claim_addr(1), "R5", g);
    chk(g == 15, "R5", g, 15);
    rd(claim_addr(1), "R5", g);
    chk(g == 31, "R5", g, 31);
    rd(claim_addr(1), "R5", g);
    chk(g == 7, "R5", g, 7);
    rd(claim_addr(1), "R5", g);
    chk(g == 0, "R5", g, 0);
    wr(claim_addr(1), 15, "R8");
    wr(claim_addr(1), 31, "R8");
    wr(claim_addr(1), 7, "R8");

    // Priority 0 excludes a source: sender 2 -> hart 3, bit 20, id 21
    wr(4*21, 0, "R10");
    wr('h1000, 32'(1) << ipi_bit(2, 3), "R10");
    chk(irq[3] == 1'b0, "R10", 32'(irq[3]), 0);
    rd(claim_addr(3), "R10", g);
    chk(g == 0, "R10", g, 0);
    wr(4*21, 2, "R10");
    chk(irq[3] == 1'b1, "R10", 32'(irq[3]), 1);

    // Warm start: one claim plus one completion clears the stale interrupt
    rd(claim_addr(3), "R6", g);
    chk(g == 21, "R6", g, 21);
    wr(claim_addr(3), g, "R8");
    chk(irq[3] == 1'b0, "R6", 32'(irq[3]), 0);

    // Mixed traffic from every sender to every target
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        wr('h1000, 32'(1) << ipi_bit(s, t), "R2");
        rd(claim_addr(t), "R2", g);
        chk(g == ipi_bit(s, t) + 1, "R2", g, 32'(ipi_bit(s, t) + 1));
        wr(claim_addr(t), g, "R8");
      end

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule